// File: doc/BRIEF.md
# Prefix-Driven Register Index Extender

This decode-stage block lets short (16-bit) instructions reach a 128-entry register file. It looks at one instruction parcel per cycle. A parcel that uses a reserved short-opcode pattern is a prefix. The block does not pass a prefix on as an instruction. Instead it stores the prefix's payload as a one-shot pending state.

The next real instruction uses that pending state. For a short instruction, each 3-bit register field becomes a 7-bit index: a per-operand 2-bit bank sits above the field and two zero bits sit below it, so the index is always a multiple of four. For a 32-bit instruction, the register fields pass through unchanged. In both cases the spare payload bits appear on a mode output while the prefixed instruction is presented. Once that instruction has been accepted, the pending state clears.

Only one prefix may be pending at a time. A second prefix that arrives while one is pending is flagged as illegal and does not change the stored state.

Top module: `prefix_extender`

## Requirements
- R1: A synchronous active-high reset clears the pending prefix. After reset, a short instruction gets the unprefixed mapping even if a prefix was pending before the reset.
- R2: A valid parcel whose bits [15:13] are 3'b100 and bits [1:0] are 2'b00 is a prefix. In that cycle `out_valid` is low, and `out_illegal` is low when no prefix is pending.
- R3: A prefixed short instruction gets indices {bank, creg, 2'b00}. The short register fields are taken as follows: rd from bits [9:7], rs1 from bits [9:7], rs2 from bits [4:2]. A short instruction is any valid parcel whose bits [1:0] are not 2'b11 and that is not a prefix.
- R4: The bank fields come from prefix bits [7:2], starting at the least significant end: rd uses bits [3:2], rs1 uses bits [5:4], rs2 uses bits [7:6].
- R5: The pending state applies only to the next valid non-prefix instruction and is cleared after that instruction. Cycles with `in_valid` low do not use it up.
- R6: A prefix that arrives while another is pending drives `out_illegal` high with `out_valid` low. The stored banks and mode stay unchanged.
- R7: With no prefix pending, each short register field maps to {2'b00, 2'b01, creg}, which is registers 8 to 15. In this case `out_prefixed` is low.
- R8: A parcel whose bits [1:0] are 2'b11 is a 32-bit instruction. Its fields rd [11:7], rs1 [19:15] and rs2 [24:20] are zero-extended to 7 bits whether or not a prefix is pending. A pending prefix is still used up by it.
- R9: `out_mode` equals prefix bits [12:8] while the prefixed instruction is presented, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Parcel present this cycle |
| in_parcel | input | 32 | Parcel; only bits [15:0] are meaningful for short parcels |
| out_valid | output | 1 | A real (non-prefix) instruction is presented |
| out_prefixed | output | 1 | The presented instruction uses a pending prefix |
| out_illegal | output | 1 | A prefix arrived while another was pending |
| out_mode | output | 5 | Side-band mode bits taken from the prefix |
| out_rd | output | 7 | Destination register index |
| out_rs1 | output | 7 | First source register index |
| out_rs2 | output | 7 | Second source register index |

## Verification
The assertions assume that `in_parcel` is meaningful only when `in_valid` is high. They also assume that an upstream length decoder has already aligned every parcel, so that bits [1:0] correctly give the length of the instruction. The stimulus changes inputs only on the falling clock edge. It builds every parcel as a well-formed prefix, short instruction or 32-bit instruction, and it holds `in_valid` low for any filler cycle.

// File: rtl/prefix_ext_pkg.sv
package prefix_ext_pkg;

    localparam int REG_W   = 7;
    localparam int CREG_W  = 3;
    localparam int BANK_W  = 2;
    localparam int FULL_W  = 5;
    localparam int NUM_OPS = 3;
    localparam int MODE_W  = 5;
    localparam int BANKS_W = NUM_OPS * BANK_W;
    localparam int PAY_W   = BANKS_W + MODE_W;
    localparam int PAD_W   = REG_W - BANK_W - CREG_W;

    localparam logic [2:0]        PFX_TOP      = 3'b100;
    localparam logic [1:0]        PFX_LOW      = 2'b00;
    localparam logic [1:0]        LONG_LOW     = 2'b11;
    localparam logic [BANK_W-1:0] DEFAULT_BANK = 2'b01;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_PREFIX,
        PK_SHORT,
        PK_LONG
    } parcel_kind_e;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [BANKS_W-1:0] banks;
    } prefix_state_t;

    function automatic parcel_kind_e classify(input logic v, input logic [15:0] p);
        if (!v)
            return PK_NONE;
        if (p[1:0] == LONG_LOW)
            return PK_LONG;
        if (p[15:13] == PFX_TOP && p[1:0] == PFX_LOW)
            return PK_PREFIX;
        return PK_SHORT;
    endfunction

    function automatic logic [REG_W-1:0] widen_short(input logic [BANK_W-1:0] b,
                                                     input logic [CREG_W-1:0] c,
                                                     input logic use_bank);
        if (use_bank)
            return {b, c, {PAD_W{1'b0}}};
        return {{PAD_W{1'b0}}, DEFAULT_BANK, c};
    endfunction

    function automatic logic [REG_W-1:0] zext_full(input logic [FULL_W-1:0] f);
        return {{(REG_W-FULL_W){1'b0}}, f};
    endfunction

endpackage

// File: rtl/prefix_classify.sv
module prefix_classify
    import prefix_ext_pkg::*;
(
    input  logic         valid,
    input  logic [15:0]  parcel_lo,
    output parcel_kind_e kind
);
    always_comb kind = classify(valid, parcel_lo);
endmodule

// File: rtl/prefix_hold.sv
module prefix_hold
    import prefix_ext_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  parcel_kind_e       kind,
    input  logic [PAY_W-1:0]   payload,
    output logic               pending,
    output prefix_state_t      state,
    output logic               illegal
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            state   <= '0;
        end else begin
            case (kind)
                PK_PREFIX: begin
                    if (!pending) begin
                        pending <= 1'b1;
                        state   <= prefix_state_t'(payload);
                    end
                end
                PK_SHORT, PK_LONG: pending <= 1'b0;
                default: ;
            endcase
        end
    end

    assign illegal = (kind == PK_PREFIX) && pending;

    // R4: a fresh prefix arms the state
    a_r4_prefix_arms: assert property (@(posedge clk) disable iff (rst)
        (kind == PK_PREFIX && !pending) |=> pending);

    // R5: the instruction after the prefix consumes it
    a_r5_consume_clears: assert property (@(posedge clk) disable iff (rst)
        (kind == PK_SHORT || kind == PK_LONG) |=> !pending);

    // R5: idle cycles keep the pending state
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (kind == PK_NONE) |=> $stable(pending) && $stable(state));

    // R6: no stacking of prefixes
    a_r6_no_stack: assert property (@(posedge clk) disable iff (rst)
        (kind == PK_PREFIX && pending) |=> pending && $stable(state));
endmodule

// File: rtl/operand_widen.sv
module operand_widen
    import prefix_ext_pkg::*;
#(
    parameter int OPS = NUM_OPS
) (
    input  parcel_kind_e                 kind,
    input  logic                         use_bank,
    input  logic [OPS*BANK_W-1:0]        banks,
    input  logic [OPS-1:0][CREG_W-1:0]   creg,
    input  logic [OPS-1:0][FULL_W-1:0]   wide,
    output logic [OPS-1:0][REG_W-1:0]    idx
);
    for (genvar i = 0; i < OPS; i++) begin : g_op
        always_comb begin
            if (kind == PK_LONG)
                idx[i] = zext_full(wide[i]);
            else
                idx[i] = widen_short(banks[i*BANK_W +: BANK_W], creg[i], use_bank);
        end
    end
endmodule

// File: rtl/prefix_extender.sv
module prefix_extender
    import prefix_ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_parcel,
    output logic              out_valid,
    output logic              out_prefixed,
    output logic              out_illegal,
    output logic [MODE_W-1:0] out_mode,
    output logic [REG_W-1:0]  out_rd,
    output logic [REG_W-1:0]  out_rs1,
    output logic [REG_W-1:0]  out_rs2
);
    parcel_kind_e                    kind;
    logic                            pending;
    prefix_state_t                   state;
    logic [NUM_OPS-1:0][CREG_W-1:0]  creg;
    logic [NUM_OPS-1:0][FULL_W-1:0]  wide;
    logic [NUM_OPS-1:0][REG_W-1:0]   idx;
    logic                            unused_hi;

    assign unused_hi = ^in_parcel[31:25];

    prefix_classify u_cls (
        .valid     (in_valid),
        .parcel_lo (in_parcel[15:0]),
        .kind      (kind)
    );

    prefix_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .payload (in_parcel[PAY_W+1:2]),
        .pending (pending),
        .state   (state),
        .illegal (out_illegal)
    );

    // operand order: 0 = rd, 1 = rs1, 2 = rs2
    assign creg[0] = in_parcel[9:7];
    assign creg[1] = in_parcel[9:7];
    assign creg[2] = in_parcel[4:2];
    assign wide[0] = in_parcel[11:7];
    assign wide[1] = in_parcel[19:15];
    assign wide[2] = in_parcel[24:20];

    operand_widen #(.OPS(NUM_OPS)) u_widen (
        .kind     (kind),
        .use_bank (pending),
        .banks    (state.banks),
        .creg     (creg),
        .wide     (wide),
        .idx      (idx)
    );

    assign out_valid    = (kind == PK_SHORT) || (kind == PK_LONG);
    assign out_prefixed = out_valid && pending;
    assign out_mode     = out_prefixed ? state.mode : '0;
    assign out_rd       = idx[0];
    assign out_rs1      = idx[1];
    assign out_rs2      = idx[2];

    // R2: a prefix is never presented as an instruction
    a_r2_prefix_hidden: assert property (@(posedge clk) disable iff (rst)
        (kind == PK_PREFIX) |-> !out_valid);

    // R6: illegal only when a prefix is already pending
    a_r6_illegal_pending: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (pending && !out_valid));

    // R9: mode is quiet for unprefixed instructions
    a_r9_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_prefixed) |-> (out_mode == '0));
endmodule

// File: tb/prefix_extender_tb_top.sv
module prefix_extender_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [31:0] in_parcel = '0;
    logic       out_valid, out_prefixed, out_illegal;
    logic [4:0] out_mode;
    logic [6:0] out_rd, out_rs1, out_rs2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    prefix_extender dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_parcel(in_parcel),
        .out_valid(out_valid), .out_prefixed(out_prefixed), .out_illegal(out_illegal),
        .out_mode(out_mode), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2)
    );

    // prefix: mode 0x15, banks rs2=2 rs1=1 rd=3
    localparam logic [31:0] P1 = 32'h0000_959C;
    // prefix: mode 0x0A, banks rs2=0 rs1=3 rd=2
    localparam logic [31:0] P2 = 32'h0000_8A38;
    // short: creg [9:7]=5, [4:2]=2
    localparam logic [31:0] C1 = 32'h0000_4289;
    // short: creg [9:7]=0, [4:2]=7
    localparam logic [31:0] C2 = 32'h0000_401D;
    // 32-bit: rd=31 rs1=17 rs2=3
    localparam logic [31:0] W1 = {7'd0, 5'd3, 5'd17, 3'd0, 5'd31, 7'h33};

    // {valid, parcel, exp_valid, exp_illegal, exp_prefixed, exp_mode, exp_rd, exp_rs1, exp_rs2}
    localparam int NV = 12;
    localparam logic [61:0] VEC [NV] = '{
        {1'b1, C1, 1'b1, 1'b0, 1'b0, 5'h00, 7'd13,  7'd13, 7'd10},
        {1'b1, P1, 1'b0, 1'b0, 1'b0, 5'h00, 7'd0,   7'd0,  7'd0 },
        {1'b0, C2, 1'b0, 1'b0, 1'b0, 5'h00, 7'd0,   7'd0,  7'd0 },
        {1'b1, P2, 1'b0, 1'b1, 1'b0, 5'h00, 7'd0,   7'd0,  7'd0 },
        {1'b1, C1, 1'b1, 1'b0, 1'b1, 5'h15, 7'd116, 7'd52, 7'd72},
        {1'b1, C1, 1'b1, 1'b0, 1'b0, 5'h00, 7'd13,  7'd13, 7'd10},
        {1'b1, P2, 1'b0, 1'b0, 1'b0, 5'h00, 7'd0,   7'd0,  7'd0 },
        {1'b1, W1, 1'b1, 1'b0, 1'b1, 5'h0A, 7'd31,  7'd17, 7'd3 },
        {1'b1, C2, 1'b1, 1'b0, 1'b0, 5'h00, 7'd8,   7'd8,  7'd15},
        {1'b1, P2, 1'b0, 1'b0, 1'b0, 5'h00, 7'd0,   7'd0,  7'd0 },
        {1'b1, C2, 1'b1, 1'b0, 1'b1, 5'h0A, 7'd64,  7'd96, 7'd28},
        {1'b1, W1, 1'b1, 1'b0, 1'b0, 5'h00, 7'd31,  7'd17, 7'd3 }
    };

    function automatic string req_of(input int i);
        case (i)
            0, 8:  return "R7";
            1, 9:  return "R2";
            2:     return "R5";
            3:     return "R6";
            4, 10: return "R3";
            5:     return "R5";
            6:     return "R4";
            7:     return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] p);
        @(negedge clk);
        in_valid  = v;
        in_parcel = p;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // reset state (R1)
        drive(1'b0, 32'h0);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_illegal in reset", int'(out_illegal), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [61:0] e;
            e = VEC[i];
            drive(e[61], e[60:29]);
            check(req_of(i), "out_valid", int'(out_valid), int'(e[28]));
            check(req_of(i), "out_illegal", int'(out_illegal), int'(e[27]));
            if (e[28]) begin
                check(req_of(i), "out_prefixed", int'(out_prefixed), int'(e[26]));
                check("R9", "out_mode", int'(out_mode), int'(e[25:21]));
                check(req_of(i), "out_rd (R4 order)", int'(out_rd), int'(e[20:14]));
                check(req_of(i), "out_rs1", int'(out_rs1), int'(e[13:7]));
                check(req_of(i), "out_rs2", int'(out_rs2), int'(e[6:0]));
            end
        end

        // R1: reset while a prefix is pending drops it
        drive(1'b1, P1);
        check("R2", "prefix out_valid", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, C1);
        check("R1", "prefixed after reset", int'(out_prefixed), 0);
        check("R1", "rd after reset", int'(out_rd), 13);
        check("R7", "rs2 after reset", int'(out_rs2), 10);

        // R6: second prefix does not overwrite banks of the first
        drive(1'b1, P2);
        drive(1'b1, P1);
        check("R6", "illegal on stacked prefix", int'(out_illegal), 1);
        drive(1'b1, C2);
        check("R6", "rd keeps first banks", int'(out_rd), 64);
        check("R6", "mode keeps first", int'(out_mode), 'h0A);
        drive(1'b0, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule